// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Detector

This block runs the reset-and-presence phase of a single-wire open-drain bus in hardware. A one-cycle start request begins the sequence. The block holds the bus low for the reset period and then lets the external pull-up raise it. It waits a fixed settle interval and then samples the bus once per microsecond across a detection window, looking for a low response from any attached device. Every interval is a whole number of microseconds counted from a 1 us tick. The tick comes from a cycle counter that is cleared when a sequence starts.

The bus input passes through a two-flop synchroniser, so each sample reflects the pin as it was two clock cycles earlier. A presence flag is set at the start of the window and any low sample clears it. The block reports completion only after the whole window has elapsed, which gives a responding device time to finish its pulse before the next bus operation. At completion it issues a one-cycle done strobe together with a failure flag that reads 1 when no device answered. The failure flag keeps its value until the next accepted start. The interface carries no data stream, so every pin is a plain control or status signal. There is no handshake and no back-pressure.

Top module: `owr_reset_presence`

## Requirements
- R1: During and after reset, drive_low_o, busy_o, done_o and no_presence_o are all 0.
- R2: A start_i seen high at a clock edge while idle makes drive_low_o 1 from that edge for exactly CLK_PER_US*RESET_US cycles. With the defaults this is 25,000 cycles.
- R3: After the reset phase the bus is released for WAIT_US microseconds. A low bus level during this settle interval, or during the reset phase, has no effect on the result.
- R4: The detection window lasts WINDOW_US microseconds. The bus is sampled at the edges start+CLK_PER_US*(RESET_US+WAIT_US+j) for j = 1..WINDOW_US, and each sample uses the bus_i level from two clock edges earlier.
- R5: no_presence_o becomes 1 at completion if every window sample was high. It becomes 0 if any window sample was low.
- R6: busy_o is 1 from the start edge for CLK_PER_US*(RESET_US+WAIT_US+WINDOW_US) cycles. done_o is a single-cycle pulse in the first cycle after busy_o falls.
- R7: A start_i pulse while busy_o is 1 is ignored. The timing, the drive and the result of the running sequence do not change.
- R8: no_presence_o is cleared to 0 at an accepted start and then holds the value set at completion until the next accepted start.
- R9: drive_low_o is 0 at all times outside the reset phase. In particular it is 0 whenever busy_o is 0 and throughout the settle and window phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a reset-and-presence sequence |
| bus_i | input | 1 | Raw level of the single-wire bus pin |
| drive_low_o | output | 1 | Active-high enable for the pin's low driver; 0 leaves the bus to the pull-up |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| no_presence_o | output | 1 | 1 when no device answered in the last completed sequence |

## Verification
Each result is due at a fixed cycle offset from the edge that accepts the start. drive_low_o falls CLK_PER_US*RESET_US edges later. busy_o falls and done_o and no_presence_o update CLK_PER_US*(RESET_US+WAIT_US+WINDOW_US) edges later. Each window sample reflects the bus two edges before its tick edge. The bench counts posedges from the accepting edge and drives bus_i for each edge on the preceding falling edge. On every falling edge it compares the outputs with the values the requirements give for that edge count. The expected presence result comes from a bench function that checks the window sample edges, less two, against the randomised or directed low interval.

// File: rtl/owr_pkg.sv
package owr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RESET  = 2'd1,
    PH_SETTLE = 2'd2,
    PH_WINDOW = 2'd3
  } owr_phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/owr_sync2.sv
module owr_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic meta_q;
  logic stable_q;

  // Both stages reset to the released (pulled-up) level.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= 1'b1;
      stable_q <= 1'b1;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> (sync_o == $past(async_i, 2))) else $error("sync latency"); // R4
endmodule

// File: rtl/owr_us_tick.sv
module owr_us_tick #(
  parameter int unsigned CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q;

  // The counter realigns on an accepted start so that the first tick lands
  // exactly CLK_PER_US edges after the start edge.
  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);

  generate
    if (CLK_PER_US > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o) else $error("tick spacing"); // R4
    end
  endgenerate
endmodule

// File: rtl/owr_phase_seq.sv
module owr_phase_seq
  import owr_pkg::*;
#(
  parameter int unsigned RESET_US  = 500,
  parameter int unsigned SETTLE_US = 60,
  parameter int unsigned WINDOW_US = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  input  logic bus_s_i,
  output logic accept_o,
  output logic busy_o,
  output logic drive_low_o,
  output logic done_o,
  output logic no_presence_o
);
  localparam int unsigned MAXLEN = max3(RESET_US, SETTLE_US, WINDOW_US);
  localparam int unsigned UW     = $clog2(MAXLEN + 1);

  owr_phase_e      phase_q;
  logic [UW-1:0]   us_q;
  logic [UW-1:0]   len_m1;
  logic            flag_q;
  logic            result_q;
  logic            done_q;
  logic            phase_end;

  always_comb begin
    unique case (phase_q)
      PH_RESET:  len_m1 = UW'(RESET_US - 1);
      PH_SETTLE: len_m1 = UW'(SETTLE_US - 1);
      PH_WINDOW: len_m1 = UW'(WINDOW_US - 1);
      default:   len_m1 = '0;
    endcase
  end

  assign accept_o  = (phase_q == PH_IDLE) && start_i;
  assign phase_end = tick_i && (phase_q != PH_IDLE) && (us_q == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      us_q     <= '0;
      flag_q   <= 1'b1;
      result_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        phase_q  <= PH_RESET;
        us_q     <= '0;
        flag_q   <= 1'b1;
        result_q <= 1'b0;
      end else if (tick_i && phase_q != PH_IDLE) begin
        if (phase_end) begin
          us_q <= '0;
          unique case (phase_q)
            PH_RESET:  phase_q <= PH_SETTLE;
            PH_SETTLE: phase_q <= PH_WINDOW;
            PH_WINDOW: begin
              phase_q  <= PH_IDLE;
              done_q   <= 1'b1;
              result_q <= flag_q & bus_s_i;
            end
            default:   phase_q <= PH_IDLE;
          endcase
        end else begin
          us_q <= us_q + 1'b1;
          if (phase_q == PH_WINDOW) flag_q <= flag_q & bus_s_i;
        end
      end
    end
  end

  assign busy_o        = (phase_q != PH_IDLE);
  assign drive_low_o   = (phase_q == PH_RESET);
  assign done_o        = done_q;
  assign no_presence_o = result_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done width"); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))) else $error("done placement"); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(no_presence_o)) else $error("result hold"); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !phase_end) |=> (busy_o && $stable(phase_q))) else $error("restart"); // R7
endmodule

// File: rtl/owr_reset_presence.sv
module owr_reset_presence #(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned RESET_US   = 500,
  parameter int unsigned SETTLE_US  = 60,
  parameter int unsigned WINDOW_US  = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bus_i,
  output logic drive_low_o,
  output logic busy_o,
  output logic done_o,
  output logic no_presence_o
);
  logic bus_s;
  logic tick;
  logic accept;

  owr_sync2 u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (bus_i),
    .sync_o  (bus_s)
  );

  owr_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  owr_phase_seq #(
    .RESET_US  (RESET_US),
    .SETTLE_US (SETTLE_US),
    .WINDOW_US (WINDOW_US)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .tick_i        (tick),
    .bus_s_i       (bus_s),
    .accept_o      (accept),
    .busy_o        (busy_o),
    .drive_low_o   (drive_low_o),
    .done_o        (done_o),
    .no_presence_o (no_presence_o)
  );

  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low_o |-> busy_o) else $error("drive outside sequence"); // R9
  AST_RELEASE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low_o) |-> busy_o) else $error("release ended sequence"); // R3
  AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (drive_low_o && !no_presence_o)) else $error("start"); // R2
endmodule

// File: tb/owr_reset_presence_bench.sv
module owr_reset_presence_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int RUS = 20;
  localparam int SUS = 6;
  localparam int WUS = 10;
  localparam int T_RESET = N * RUS;
  localparam int T_TOTAL = N * (RUS + SUS + WUS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic bus_i = 1'b1;
  logic drive_low_o, busy_o, done_o, no_presence_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  owr_reset_presence #(
    .CLK_PER_US(N), .RESET_US(RUS), .SETTLE_US(SUS), .WINDOW_US(WUS)
  ) u_owr_reset_presence (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_i(bus_i),
    .drive_low_o(drive_low_o), .busy_o(busy_o), .done_o(done_o),
    .no_presence_o(no_presence_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not end (actual hung, expected finish)");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Edge k after the start edge samples the bus level of edge k-2 (R4, R5).
  function automatic logic exp_nopres(input int lo_a, input int lo_b);
    for (int j = 1; j <= WUS; j++) begin
      int k;
      k = N * (RUS + SUS + j) - 2;
      if (k >= lo_a && k < lo_b) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Bus is low for edges in [lo_a, lo_b) counted from the accepting edge.
  task automatic run_seq(input int lo_a, input int lo_b, input int busy_start_c);
    logic exp_np;
    exp_np = exp_nopres(lo_a, lo_b);
    @(negedge clk);
    start_i = 1'b1;
    bus_i   = 1'b1;
    for (int c = 1; c <= T_TOTAL + 3; c++) begin
      @(negedge clk);
      start_i = (c == busy_start_c);
      bus_i   = !(c >= lo_a && c < lo_b);
      check("R2", drive_low_o, (c - 1) < T_RESET);
      check("R6 busy", busy_o, (c - 1) < T_TOTAL);
      check("R6 done", done_o, (c - 1) == T_TOTAL);
      if (c == 1) check("R8 clear", no_presence_o, 1'b0);
      if (c - 1 >= T_RESET) check("R9", drive_low_o, 1'b0);
      if (c - 1 == T_TOTAL) check("R5", no_presence_o, exp_np);
      if (c - 1 == T_TOTAL + 2) check("R8 hold", no_presence_o, exp_np);
    end
    start_i = 1'b0;
    bus_i   = 1'b1;
  endtask

  initial begin
    int k1, kl;
    void'($urandom(32'd20240611));
    k1 = N * (RUS + SUS + 1) - 2;
    kl = N * (RUS + SUS + WUS) - 2;
    repeat (4) @(negedge clk);
    check("R1", drive_low_o, 1'b0);
    check("R1", busy_o, 1'b0);
    check("R1", done_o, 1'b0);
    check("R1", no_presence_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", busy_o, 1'b0);

    run_seq(0, 0, 0);                          // R5: nobody answers
    run_seq(k1 - 8, kl + 8, 0);                // R5: answer spans window
    run_seq(T_RESET, k1, 0);                   // R3: low only in settle, ends before first sample
    run_seq(2, T_RESET - 1, 0);                // R3: low during reset phase
    run_seq(k1, k1 + 1, 0);                    // R4: one-cycle low at first sample
    run_seq(kl, kl + 1, 0);                    // R4: one-cycle low at last sample
    run_seq(kl - 1, kl, 0);                    // R4: low one edge before last sample
    run_seq(k1 + 1, k1 + N - 1, 0);            // R4: low strictly between samples
    run_seq(0, 0, T_RESET / 2);                // R7: start during reset phase
    run_seq(k1, k1 + 12, T_RESET + 3);         // R7: start during settle
    run_seq(0, 0, T_TOTAL - 1);                // R7: start on the last busy cycle

    for (int i = 0; i < 20; i++) begin
      int a, len, bs;
      a   = int'($urandom_range(T_TOTAL + 2, 1));
      len = int'($urandom_range(3 * N, 1));
      bs  = ($urandom_range(1, 0) == 1) ? int'($urandom_range(T_TOTAL - 1, 2)) : 0;
      run_seq(a, a + len, bs);                 // R3 R4 R5 R7 random
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule